// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the levels of 32 already-synchronized GPIO pins into interrupt events. Each pin can be set up to sense a level (high or low) or an edge (rising, falling, or both). Edge events are held until software acknowledges them. Level events track the pin directly and are never stored. Enable and mask bits gate each pin. All pending, unmasked pins are ORed into one interrupt line toward the system.

Every configuration register is written as two halfwords. A halfword carries a 16-bit write-select field in bits 31:16 and a 16-bit data field in bits 15:0. Only the data bits whose select bit is 1 are changed, so no read-modify-write is needed. Reads return one halfword per access.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every configuration register and every latched edge event is 0, `irq_o` is low, and all reads return 0.
- R2: On a write, bit k of the addressed halfword changes to `wr_data[k]` only when `wr_data[16+k]` is 1; otherwise it keeps its value. The base offset holds pins 0..15 and base+4 holds pins 16..31. A read of either offset returns that halfword in `rd_data`.
- R3: The register bases are: enable 0x10, mask 0x18, sense type 0x20, polarity 0x28, dual-edge 0x30, masked status 0x50 (read only), raw status 0x58 (read only), acknowledge 0x60 (write only; reads as 0).
- R4: A pin whose enable bit is 0 never sets its raw status bit, whatever its pin activity.
- R5: With sense type 1 (edge), polarity 1 selects rising edges and polarity 0 selects falling edges. A detected edge sets the raw bit from the first clock edge after the pin change. The bit stays set until it is acknowledged.
- R6: With sense type 0 (level), the raw bit is 1 exactly while the pin equals its polarity bit (1 means active high, 0 means active low). It follows the pin in the same cycle and is not held.
- R7: When a pin's dual-edge bit is 1, an edge-type pin detects both rising and falling edges whatever its polarity bit says.
- R8: The status equals raw AND enable AND NOT mask. A mask bit of 1 hides the pin from the status and from `irq_o` but leaves the raw status unchanged.
- R9: `irq_o` is the OR of all 32 status bits.
- R10: Writing a 1 to a selected acknowledge bit clears that pin's held edge event. Writing a 0, or leaving the bit unselected, leaves the event as it is.
- R11: If a new qualifying edge and an acknowledge of the same pin fall in the same cycle, the raw bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Synchronized pin levels |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write select in bits 31:16, data in bits 15:0 |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 16 | Halfword read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The acknowledge write and the edge detector can act on the same held bit in the same cycle. The bench provokes this in two ways. A directed case drives a rising pin in the same cycle as an acknowledge of that pin, and the raw bit must read back 1. The random phase also mixes acknowledge writes with pin toggles. In every cycle a bench model computes the expected raw value as the held bit with the clear applied first and the new edge ORed after. The raw status, masked status and `irq_o` are compared against that model.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_EN   = 8'h10,
  parameter logic [AW-1:0] OFS_MSK  = 8'h18,
  parameter logic [AW-1:0] OFS_TYP  = 8'h20,
  parameter logic [AW-1:0] OFS_POL  = 8'h28,
  parameter logic [AW-1:0] OFS_DUAL = 8'h30,
  parameter logic [AW-1:0] OFS_STAT = 8'h50,
  parameter logic [AW-1:0] OFS_RAW  = 8'h58,
  parameter logic [AW-1:0] OFS_ACK  = 8'h60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   pin_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic          irq_o
);
  localparam int NPIN = 32;
  localparam int HW = NPIN / 2;
  localparam logic [AW-1:0] HI = AW'(4);

  logic [NPIN-1:0] en_q, msk_q, typ_q, pol_q, dual_q, edge_q, pin_q;
  logic [NPIN-1:0] rise, fall, edge_hit, edge_set, ack_clr, lvl_raw, raw, stat;

  function automatic logic [NPIN-1:0] upd(input logic [NPIN-1:0] old, input logic [AW-1:0] base,
                                          input logic we, input logic [AW-1:0] a, input logic [31:0] d);
    upd = old;
    if (we && a == base)      upd[HW-1:0]    = (old[HW-1:0]    & ~d[31:16]) | (d[15:0] & d[31:16]);
    if (we && a == base + HI) upd[NPIN-1:HW] = (old[NPIN-1:HW] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  function automatic logic [15:0] pick(input logic [NPIN-1:0] v, input logic [AW-1:0] base,
                                       input logic [AW-1:0] a);
    pick = (a == base) ? v[HW-1:0] : (a == base + HI) ? v[NPIN-1:HW] : 16'h0;
  endfunction

  assign ack_clr = {(wr_en && wr_addr == OFS_ACK + HI) ? wr_data[31:16] & wr_data[15:0] : 16'h0,
                    (wr_en && wr_addr == OFS_ACK)      ? wr_data[31:16] & wr_data[15:0] : 16'h0};

  assign rise     = pin_i & ~pin_q;
  assign fall     = ~pin_i & pin_q;
  assign edge_hit = (dual_q & (rise | fall)) | (~dual_q & ((pol_q & rise) | (~pol_q & fall)));
  assign edge_set = edge_hit & typ_q & en_q;
  assign lvl_raw  = ~typ_q & en_q & ~(pin_i ^ pol_q);
  assign raw      = (typ_q & edge_q) | lvl_raw;
  assign stat     = raw & en_q & ~msk_q;
  assign irq_o    = |stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; msk_q <= '0; typ_q <= '0; pol_q <= '0; dual_q <= '0;
      edge_q <= '0; pin_q <= '0;
    end else begin
      en_q   <= upd(en_q,   OFS_EN,   wr_en, wr_addr, wr_data);
      msk_q  <= upd(msk_q,  OFS_MSK,  wr_en, wr_addr, wr_data);
      typ_q  <= upd(typ_q,  OFS_TYP,  wr_en, wr_addr, wr_data);
      pol_q  <= upd(pol_q,  OFS_POL,  wr_en, wr_addr, wr_data);
      dual_q <= upd(dual_q, OFS_DUAL, wr_en, wr_addr, wr_data);
      edge_q <= (edge_q & ~ack_clr) | edge_set;
      pin_q  <= pin_i;
    end
  end

  assign rd_data = pick(en_q, OFS_EN, rd_addr) | pick(msk_q, OFS_MSK, rd_addr)
                 | pick(typ_q, OFS_TYP, rd_addr) | pick(pol_q, OFS_POL, rd_addr)
                 | pick(dual_q, OFS_DUAL, rd_addr) | pick(stat, OFS_STAT, rd_addr)
                 | pick(raw, OFS_RAW, rd_addr);

  a_r4_disabled_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && edge_q == '0) |=> edge_q == '0);
  a_r11_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_set != '0) |=> ((edge_q & $past(edge_set)) == $past(edge_set)));
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_clr & edge_q) != '0) |=> ((edge_q & $past(ack_clr & ~edge_set)) == '0));
  a_r8_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '1) |-> !irq_o);
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
endmodule

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  logic clk = 0, rst_n = 0, wr_en = 0, irq_o;
  logic [31:0] pin_i = 0, wr_data = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] rd_data;
  int errs = 0, checks = 0;
  bit done = 0;

  logic [31:0] m_en = 0, m_msk = 0, m_typ = 0, m_pol = 0, m_dual = 0, m_edge = 0, m_prev = 0;

  gpio_irq_detect u0 (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
                      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o));

  always #5 clk = ~clk;

  function automatic logic [31:0] mupd(logic [31:0] old, logic [7:0] base);
    logic [31:0] r = old;
    if (wr_en && wr_addr == base)      r[15:0]  = (old[15:0]  & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
    if (wr_en && wr_addr == base + 4)  r[31:16] = (old[31:16] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
    return r;
  endfunction

  function automatic logic [31:0] exp_raw();
    return (m_typ & m_edge) | (~m_typ & m_en & ~(pin_i ^ m_pol));
  endfunction

  task automatic cyc();
    logic [31:0] rise = pin_i & ~m_prev, fall = ~pin_i & m_prev, set, clr;
    set = ((m_dual & (rise | fall)) | (~m_dual & ((m_pol & rise) | (~m_pol & fall)))) & m_typ & m_en;
    clr = 0;
    if (wr_en && wr_addr == 8'h60) clr[15:0]  = wr_data[31:16] & wr_data[15:0];
    if (wr_en && wr_addr == 8'h64) clr[31:16] = wr_data[31:16] & wr_data[15:0];
    @(posedge clk);
    m_edge = (m_edge & ~clr) | set;
    m_en = mupd(m_en, 8'h10); m_msk = mupd(m_msk, 8'h18); m_typ = mupd(m_typ, 8'h20);
    m_pol = mupd(m_pol, 8'h28); m_dual = mupd(m_dual, 8'h30);
    m_prev = pin_i;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] sel, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = {sel, d};
    cyc();
  endtask

  task automatic chk16(string tag, logic [7:0] a, logic [15:0] exp);
    rd_addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      errs++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk_all(string tag);
    logic [31:0] r = exp_raw(), s;
    s = r & m_en & ~m_msk;
    chk16(tag, 8'h58, r[15:0]); chk16(tag, 8'h5c, r[31:16]);
    chk16(tag, 8'h50, s[15:0]); chk16(tag, 8'h54, s[31:16]);
    checks++;
    if (irq_o !== (|s)) begin
      errs++;
      $display("FAIL %s R9 irq actual=%b expected=%b", tag, irq_o, |s);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    chk16("R1 reset", 8'h10, 16'h0);
    rst_n = 1;
    @(negedge clk);
    // R2 masked halfword writes
    wr(8'h10, 16'h00ff, 16'hffff); chk16("R2 lo", 8'h10, m_en[15:0]);
    wr(8'h10, 16'hff00, 16'h0000); chk16("R2 unselected kept", 8'h10, 16'h00ff);
    chk16("R2 hi", 8'h14, 16'h0000);
    wr(8'h14, 16'hffff, 16'h8001); chk16("R2 hi", 8'h14, 16'h8001);
    // R3 offsets readback
    wr(8'h18, 16'hffff, 16'h1111); wr(8'h20, 16'hffff, 16'h2222);
    wr(8'h28, 16'hffff, 16'h4444); wr(8'h30, 16'hffff, 16'h8888);
    chk16("R3 mask", 8'h18, 16'h1111); chk16("R3 type", 8'h20, 16'h2222);
    chk16("R3 pol", 8'h28, 16'h4444); chk16("R3 dual", 8'h30, 16'h8888);
    chk16("R3 ack reads 0", 8'h60, 16'h0);
    // clean config: pins 0..3 edge, enabled; pin 4 edge disabled
    wr(8'h10, 16'hffff, 16'h000f); wr(8'h14, 16'hffff, 16'h0);
    wr(8'h18, 16'hffff, 16'h0);    wr(8'h20, 16'hffff, 16'h001f);
    wr(8'h28, 16'hffff, 16'h0005); wr(8'h30, 16'hffff, 16'h0008);
    chk_all("R1 idle");
    // R4: disabled pin 4 toggles
    pin_i[4] = 1; cyc(); pin_i[4] = 0; cyc(); chk_all("R4 disabled");
    // R5 rising on pin0 (pol 1), falling on pin1 (pol 0)
    pin_i[0] = 1; pin_i[1] = 1; cyc(); chk_all("R5 rise");
    pin_i[0] = 0; pin_i[1] = 0; cyc(); chk_all("R5 fall held");
    // R7 dual edge pin3 with pol 0
    pin_i[3] = 1; cyc(); chk_all("R7 dual rise");
    wr(8'h60, 16'h0008, 16'h0008); chk_all("R10 ack pin3");
    pin_i[3] = 0; cyc(); chk_all("R7 dual fall");
    // R10 ack with 0 data no effect, then real ack
    wr(8'h60, 16'hffff, 16'h0000); chk_all("R10 zero ack");
    wr(8'h60, 16'h0003, 16'hffff); chk_all("R10 ack");
    // R11 collision: pin0 rises while acked
    wr(8'h60, 16'h0001, 16'h0001); chk_all("R11 setup");
    pin_i[0] = 0; cyc();
    pin_i[0] = 1; wr_en = 1; wr_addr = 8'h60; wr_data = 32'h0001_0001; cyc();
    checks++;
    if (m_edge[0] !== 1'b1) begin errs++; $display("FAIL R11 model actual=0 expected=1"); end
    chk_all("R11 edge wins");
    // R8 mask hides status not raw
    wr(8'h18, 16'h0001, 16'h0001); chk_all("R8 masked");
    // R6 level high on pin 8, low on pin 9
    wr(8'h10, 16'h0300, 16'h0300); wr(8'h28, 16'h0300, 16'h0100);
    pin_i[8] = 1; pin_i[9] = 1; #1; chk_all("R6 level same cycle");
    pin_i[8] = 0; pin_i[9] = 0; #1; chk_all("R6 level follows");
    // random phase
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 7);
      logic [7:0] a;
      pin_i = pin_i ^ ($urandom() & $urandom());
      case (k)
        0: a = 8'h10; 1: a = 8'h18; 2: a = 8'h20; 3: a = 8'h28;
        4: a = 8'h30; default: a = 8'h60;
      endcase
      if ($urandom_range(0, 1) == 1) a = a + 8'd4;
      if ($urandom_range(0, 2) != 0) begin
        wr_en = 1; wr_addr = a; wr_data = $urandom();
      end
      cyc();
      chk_all("R5 R6 R7 R8 R10 R11 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule